// File: doc/BRIEF.md
# Per-Bank SDRAM Command Timing Gate

This block sits between the scheduling front end of a memory controller and the command pins of a four-bank DDR SDRAM. The front end presents one command request at a time: a command code, a bank number and an auto-precharge flag. The gate keeps track of which banks hold an open row. For every bank it runs down-counters for the minimum spacings between commands, and for the whole device it runs the spacings that span all banks. In the same cycle it decides whether the request may go out. A granted request appears at once on the encoded strobes. A request that is legal but early is stalled, and the front end holds it until the grant comes. A request that breaks the open/closed protocol is rejected with an error pulse.

All spacings are parameters. Times in picoseconds are converted to clocks by a ceiling division by the clock period. The defaults describe a 300 MHz clock with read latency 4: row cycle 15, row active 10, activate-to-read 5, activate-to-write 3, precharge 5, bank-to-bank activate 3, refresh cycle 17, and precharge-after-write recovery 5.

Top module: `sdram_timing_gate`

## Requirements
- R1: While reset is high and after its release, `bank_open` is all zero, `grant` and `proto_err` are low, and the four strobes read 1111 (deselected).
- R2: Command codes are NOP 0, ACT 1, RD 2, WR 3, PRE 4, PREA 5, REF 6 and 7 reserved; NOP and 7 are never granted. On a grant the strobes {cs_n,ras_n,cas_n,we_n} are ACT 0011, RD 0101, WR 0100, PRE and PREA 0010, REF 0001. `cmd_ap` is high for PREA and for RD or WR with the auto-precharge flag, and `cmd_bank` equals `req_bank`. When nothing is granted the strobes are 1111.
- R3: A read to a bank is granted no earlier than 5 cycles after that bank's ACT grant. A write is granted no earlier than max(5-2, 2) = 3 cycles after it.
- R4: An explicit precharge of an open bank waits 10 cycles after its ACT, 2 cycles after its last read and 5 cycles (read latency + 1) after its last write. The longest of these applies.
- R5: An ACT waits 5 cycles after the bank's precharge. It also waits max(15, 10+5) = 15 cycles after the bank's previous ACT.
- R6: Any two ACT grants, on any banks, are at least 3 cycles apart.
- R7: A read or write granted with auto-precharge clears the bank's `bank_open` in the next cycle. The internal precharge takes place once the precharge condition of R4 holds. The next ACT to that bank waits a further 5 cycles after that point.
- R8: A REF with any bank open is a protocol error. A REF is stalled while any bank is still waiting for an auto-precharge or is inside its precharge time. ACT and REF are both held off for 17 cycles after a granted REF.
- R9: RD or WR to a closed bank and ACT to an open bank raise `proto_err` in the same cycle. They get no grant and change no state.
- R10: The grant is combinational in the cycle its conditions are met, so a held request goes out in the first eligible cycle. Column commands to an open bank may follow each other in consecutive cycles.
- R11: PREA is granted only when every open bank meets its R4 condition and no auto-precharge is pending. It closes all open banks and starts their precharge times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 3 | Command code (see R2) |
| req_bank | input | 2 | Target bank |
| req_ap | input | 1 | Auto-precharge flag for RD/WR |
| grant | output | 1 | Request issued this cycle |
| proto_err | output | 1 | Request rejected as a protocol error |
| cmd_cs_n | output | 1 | Chip select strobe, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write strobe, active low |
| cmd_ap | output | 1 | Auto-precharge / all-bank flag |
| cmd_bank | output | 2 | Bank address driven with the command |
| bank_open | output | 4 | One bit per bank, set while a row is open |

## Verification
The hardest case to reach from the ports is an auto-precharge that is still pending while other commands want the same resources. In that case the bank already reads as closed but cannot yet be activated, refreshed or swept by PREA. The stimulus gets there by issuing a write with auto-precharge shortly after the activate, so the tRAS remainder and the write recovery compete. It then holds an ACT to that bank, and a PREA, until each is granted. The per-cycle reference model predicts the exact cycle of each grant, so a spacing that is off by one cycle shows up.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_REF  = 3'd6,
        CMD_RSV  = 3'd7
    } tg_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } tg_pins_t;

    localparam tg_pins_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // Readiness flags that one bank tracker reports to the grant logic.
    typedef struct packed {
        logic is_open;
        logic act_ok;
        logic rd_ok;
        logic wr_ok;
        logic pre_ok;
        logic ref_ok;
    } tg_bank_stat_t;

    // Time to clocks, always rounded up.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tg_downcnt.sv
module tg_downcnt #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          done
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign done = (count == '0);
endmodule

// File: rtl/tg_bank.sv
module tg_bank
    import tg_pkg::*;
#(
    parameter int CW     = 5,
    parameter int RCD_RD = 5,
    parameter int RCD_WR = 3,
    parameter int RAS    = 10,
    parameter int RC     = 15,
    parameter int RP     = 5,
    parameter int RTP    = 2,
    parameter int WRA    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act_go,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic          pre_go,
    input  logic          auto_pre,
    output tg_bank_stat_t stat
);
    // A counter loaded with N-1 reaches zero exactly N cycles after the load.
    localparam logic [CW-1:0] L_RCD_RD = CW'(RCD_RD - 1);
    localparam logic [CW-1:0] L_RCD_WR = CW'(RCD_WR - 1);
    localparam logic [CW-1:0] L_RAS    = CW'(RAS - 1);
    localparam logic [CW-1:0] L_RC     = CW'(RC - 1);
    localparam logic [CW-1:0] L_RP     = CW'(RP - 1);
    localparam logic [CW-1:0] L_RTP    = CW'(RTP - 1);
    localparam logic [CW-1:0] L_WRA    = CW'(WRA - 1);

    logic          is_open, ap_pend;
    logic [CW-1:0] rcdr_cnt, rcdw_cnt, pw_cnt, rp_cnt, rc_cnt;
    logic          rcdr_done, rcdw_done, pw_done, rp_done, rc_done;
    logic [CW-1:0] pw_next, pw_load;
    logic          ap_fire, col_ap, rp_load;

    assign col_ap  = (rd_go || wr_go) && auto_pre;
    assign ap_fire = ap_pend && pw_done;
    assign rp_load = (pre_go && is_open) || ap_fire;

    // Precharge wait folds tRAS and read/write recovery into one counter.
    always_comb begin
        pw_next = pw_done ? '0 : pw_cnt - 1'b1;
        if (act_go)
            pw_load = L_RAS;
        else if (wr_go)
            pw_load = (pw_next > L_WRA) ? pw_next : L_WRA;
        else
            pw_load = (pw_next > L_RTP) ? pw_next : L_RTP;
    end

    tg_downcnt #(.CW(CW)) u_rcdr (.clk(clk), .rst(rst), .load(act_go), .load_val(L_RCD_RD),
                                  .count(rcdr_cnt), .done(rcdr_done));
    tg_downcnt #(.CW(CW)) u_rcdw (.clk(clk), .rst(rst), .load(act_go), .load_val(L_RCD_WR),
                                  .count(rcdw_cnt), .done(rcdw_done));
    tg_downcnt #(.CW(CW)) u_pw   (.clk(clk), .rst(rst), .load(act_go || rd_go || wr_go),
                                  .load_val(pw_load), .count(pw_cnt), .done(pw_done));
    tg_downcnt #(.CW(CW)) u_rp   (.clk(clk), .rst(rst), .load(rp_load), .load_val(L_RP),
                                  .count(rp_cnt), .done(rp_done));
    tg_downcnt #(.CW(CW)) u_rc   (.clk(clk), .rst(rst), .load(act_go), .load_val(L_RC),
                                  .count(rc_cnt), .done(rc_done));

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            ap_pend <= 1'b0;
        end else begin
            if (act_go)
                is_open <= 1'b1;
            else if (pre_go || col_ap)
                is_open <= 1'b0;

            if (col_ap)
                ap_pend <= 1'b1;
            else if (ap_fire)
                ap_pend <= 1'b0;
        end
    end

    always_comb begin
        stat.is_open = is_open;
        stat.act_ok  = !is_open && !ap_pend && rp_done && rc_done;
        stat.rd_ok   = is_open && rcdr_done;
        stat.wr_ok   = is_open && rcdw_done;
        stat.pre_ok  = !ap_pend && (!is_open || pw_done);
        stat.ref_ok  = !is_open && !ap_pend && rp_done;
    end
endmodule

// File: rtl/tg_encode.sv
module tg_encode
    import tg_pkg::*;
(
    input  logic     grant,
    input  tg_cmd_e  cmd,
    input  logic     auto_pre,
    output tg_pins_t pins,
    output logic     ap_flag
);
    always_comb begin
        pins    = PINS_DESEL;
        ap_flag = 1'b0;
        if (grant) begin
            pins.cs_n = 1'b0;
            case (cmd)
                CMD_ACT:  pins.ras_n = 1'b0;
                CMD_RD:   begin pins.cas_n = 1'b0; ap_flag = auto_pre; end
                CMD_WR:   begin pins.cas_n = 1'b0; pins.we_n = 1'b0; ap_flag = auto_pre; end
                CMD_PRE:  begin pins.ras_n = 1'b0; pins.we_n = 1'b0; end
                CMD_PREA: begin pins.ras_n = 1'b0; pins.we_n = 1'b0; ap_flag = 1'b1; end
                CMD_REF:  begin pins.ras_n = 1'b0; pins.cas_n = 1'b0; end
                default:  pins = PINS_DESEL;
            endcase
        end
    end
endmodule

// File: rtl/sdram_timing_gate.sv
module sdram_timing_gate
    import tg_pkg::*;
#(
    parameter int NB     = 4,
    parameter int CLK_PS = 3300,
    parameter int RC_PS  = 49500,
    parameter int RAS_PS = 33000,
    parameter int RCD_PS = 16500,
    parameter int RP_PS  = 16500,
    parameter int RFC_PS = 56100,
    parameter int T_RRD  = 3,
    parameter int T_CL   = 4,
    parameter int T_RTP  = 2,
    localparam int BW    = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_cmd,
    input  logic [BW-1:0] req_bank,
    input  logic          req_ap,
    output logic          grant,
    output logic          proto_err,
    output logic          cmd_cs_n,
    output logic          cmd_ras_n,
    output logic          cmd_cas_n,
    output logic          cmd_we_n,
    output logic          cmd_ap,
    output logic [BW-1:0] cmd_bank,
    output logic [NB-1:0] bank_open
);
    localparam int T_RAS_C    = ceil_div(RAS_PS, CLK_PS);
    localparam int T_RP_C     = ceil_div(RP_PS, CLK_PS);
    localparam int T_RC_C     = max2(ceil_div(RC_PS, CLK_PS), T_RAS_C + T_RP_C);
    localparam int T_RCD_RD_C = ceil_div(RCD_PS, CLK_PS);
    localparam int T_RCD_WR_C = max2(T_RCD_RD_C - 2, 2);
    localparam int T_RFC_C    = ceil_div(RFC_PS, CLK_PS);
    localparam int T_WRA_C    = T_CL + 1;
    localparam int CW         = $clog2(max2(max2(T_RC_C, T_RFC_C), max2(T_RRD, T_WRA_C)) + 1);

    tg_cmd_e cmd;
    assign cmd = tg_cmd_e'(req_cmd);

    logic [NB-1:0] hit, act_go, rd_go, wr_go, pre_go;
    logic [NB-1:0] v_open, v_act_ok, v_rd_ok, v_wr_ok, v_pre_ok, v_ref_ok;

    for (genvar i = 0; i < NB; i++) begin : g_bank
        tg_bank_stat_t st;

        assign hit[i]    = (req_bank == BW'(i));
        assign act_go[i] = grant && (cmd == CMD_ACT) && hit[i];
        assign rd_go[i]  = grant && (cmd == CMD_RD) && hit[i];
        assign wr_go[i]  = grant && (cmd == CMD_WR) && hit[i];
        assign pre_go[i] = grant && (((cmd == CMD_PRE) && hit[i]) || (cmd == CMD_PREA));

        tg_bank #(
            .CW(CW), .RCD_RD(T_RCD_RD_C), .RCD_WR(T_RCD_WR_C), .RAS(T_RAS_C),
            .RC(T_RC_C), .RP(T_RP_C), .RTP(T_RTP), .WRA(T_WRA_C)
        ) u_bank (
            .clk(clk), .rst(rst), .act_go(act_go[i]), .rd_go(rd_go[i]), .wr_go(wr_go[i]),
            .pre_go(pre_go[i]), .auto_pre(req_ap), .stat(st)
        );

        assign v_open[i]   = st.is_open;
        assign v_act_ok[i] = st.act_ok;
        assign v_rd_ok[i]  = st.rd_ok;
        assign v_wr_ok[i]  = st.wr_ok;
        assign v_pre_ok[i] = st.pre_ok;
        assign v_ref_ok[i] = st.ref_ok;
    end

    // Device-wide spacings.
    logic [CW-1:0] rrd_cnt, rfc_cnt;
    logic          rrd_done, rfc_done;

    tg_downcnt #(.CW(CW)) u_rrd (.clk(clk), .rst(rst), .load(grant && (cmd == CMD_ACT)),
                                 .load_val(CW'(T_RRD - 1)), .count(rrd_cnt), .done(rrd_done));
    tg_downcnt #(.CW(CW)) u_rfc (.clk(clk), .rst(rst), .load(grant && (cmd == CMD_REF)),
                                 .load_val(CW'(T_RFC_C - 1)), .count(rfc_cnt), .done(rfc_done));

    logic ok, err;
    always_comb begin
        ok  = 1'b0;
        err = 1'b0;
        case (cmd)
            CMD_ACT: begin
                err = v_open[req_bank];
                ok  = v_act_ok[req_bank] && rrd_done && rfc_done;
            end
            CMD_RD: begin
                err = !v_open[req_bank];
                ok  = v_rd_ok[req_bank];
            end
            CMD_WR: begin
                err = !v_open[req_bank];
                ok  = v_wr_ok[req_bank];
            end
            CMD_PRE:  ok = v_pre_ok[req_bank];
            CMD_PREA: ok = &v_pre_ok;
            CMD_REF: begin
                err = |v_open;
                ok  = (&v_ref_ok) && rfc_done;
            end
            default: begin
                ok  = 1'b0;
                err = 1'b0;
            end
        endcase
    end

    assign grant     = req_valid && ok && !err;
    assign proto_err = req_valid && err;

    tg_pins_t pins;
    tg_encode u_enc (.grant(grant), .cmd(cmd), .auto_pre(req_ap), .pins(pins), .ap_flag(cmd_ap));

    assign cmd_cs_n  = pins.cs_n;
    assign cmd_ras_n = pins.ras_n;
    assign cmd_cas_n = pins.cas_n;
    assign cmd_we_n  = pins.we_n;
    assign cmd_bank  = req_bank;
    assign bank_open = v_open;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
    parameter int NB     = 4,
    parameter int RCD_RD = 5,
    parameter int RAS    = 10,
    parameter int RRD    = 3,
    localparam int BW    = $clog2(NB)
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    req_cmd,
    input logic [BW-1:0] req_bank,
    input logic          grant,
    input logic          proto_err,
    input logic          cmd_cs_n,
    input logic [NB-1:0] bank_open
);
    logic [7:0] since_any;
    logic [7:0] since_act [NB];

    always_ff @(posedge clk) begin
        if (rst) begin
            since_any <= 8'hff;
            for (int b = 0; b < NB; b++) since_act[b] <= 8'hff;
        end else begin
            if (grant && req_cmd == 3'd1) since_any <= 8'd1;
            else if (since_any != 8'hff) since_any <= since_any + 8'd1;
            for (int b = 0; b < NB; b++) begin
                if (grant && req_cmd == 3'd1 && req_bank == BW'(b)) since_act[b] <= 8'd1;
                else if (since_act[b] != 8'hff) since_act[b] <= since_act[b] + 8'd1;
            end
        end
    end

    a_r9_err_blocks_grant: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> (!grant && cmd_cs_n));

    a_r6_act_spacing: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 3'd1) |-> (since_any >= 8'(RRD)));

    a_r8_refresh_closed: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 3'd6) |-> (bank_open == '0));

    for (genvar b = 0; b < NB; b++) begin : g_chk
        a_r3_act_to_read: assert property (@(posedge clk) disable iff (rst)
            (grant && req_cmd == 3'd2 && req_bank == BW'(b)) |-> (since_act[b] >= 8'(RCD_RD)));

        a_r4_ras_before_pre: assert property (@(posedge clk) disable iff (rst)
            (grant && req_cmd == 3'd4 && req_bank == BW'(b) && bank_open[b])
                |-> (since_act[b] >= 8'(RAS)));

        a_r7_open_needs_act: assert property (@(posedge clk) disable iff (rst)
            $rose(bank_open[b]) |-> $past(grant && req_cmd == 3'd1 && req_bank == BW'(b)));
    end
endmodule

bind sdram_timing_gate tg_checker #(
    .NB(NB), .RCD_RD(T_RCD_RD_C), .RAS(T_RAS_C), .RRD(T_RRD)
) i_chk (
    .clk(clk), .rst(rst), .req_cmd(req_cmd), .req_bank(req_bank), .grant(grant),
    .proto_err(proto_err), .cmd_cs_n(cmd_cs_n), .bank_open(bank_open)
);

// File: tb/test_sdram_timing_gate.sv
module test_sdram_timing_gate;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;
    // Expected spacings in clocks, from the requirements.
    localparam int E_RCD = 5, E_RCDW = 3, E_RAS = 10, E_RC = 15, E_RP = 5;
    localparam int E_RRD = 3, E_RFC = 17, E_RTP = 2, E_WRA = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic req_ap = 1'b0;
    logic grant, proto_err, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_ap;
    logic [1:0] cmd_bank;
    logic [3:0] bank_open;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_timing_gate i_sdram_timing_gate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
        .req_ap(req_ap), .grant(grant), .proto_err(proto_err), .cmd_cs_n(cmd_cs_n),
        .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_ap(cmd_ap),
        .cmd_bank(cmd_bank), .bank_open(bank_open)
    );

    int    n_chk = 0, n_fail = 0, edges = 0, t = 0;
    string cur_req = "R1";

    // Reference model state: earliest legal cycles per bank.
    bit m_open [4];
    int m_rd [4], m_wr [4], m_pre [4], m_act [4], m_rp [4], m_ap [4];
    int m_rrd, m_rfc;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, t);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [3:0] exp_pins(input logic [2:0] c);
        case (c)
            3'd1:      return 4'b0011;
            3'd2:      return 4'b0101;
            3'd3:      return 4'b0100;
            3'd4, 3'd5: return 4'b0010;
            3'd6:      return 4'b0001;
            default:   return 4'b1111;
        endcase
    endfunction

    always @(posedge clk) edges++;

    // Per-cycle comparison against the behavioural model.
    always begin
        @(negedge clk);
        #2;
        t++;
        if (rst) begin
            for (int b = 0; b < 4; b++) begin
                m_open[b] = 0; m_rd[b] = 0; m_wr[b] = 0; m_pre[b] = 0;
                m_act[b] = 0; m_rp[b] = 0; m_ap[b] = -1;
            end
            m_rrd = 0; m_rfc = 0;
        end
        if (edges > 0) begin
            bit e_grant, e_err, all_ok, any_open;
            int b;
            b = int'(req_bank);
            e_grant = 0; e_err = 0;
            if (req_valid && !rst) begin
                case (req_cmd)
                    3'd1: if (m_open[b]) e_err = 1;
                          else e_grant = (t >= m_act[b]) && (t >= m_rrd) && (t >= m_rfc) && (t > m_ap[b]);
                    3'd2: if (!m_open[b]) e_err = 1; else e_grant = (t >= m_rd[b]);
                    3'd3: if (!m_open[b]) e_err = 1; else e_grant = (t >= m_wr[b]);
                    3'd4: e_grant = (t > m_ap[b]) && (!m_open[b] || t >= m_pre[b]);
                    3'd5: begin
                        all_ok = 1;
                        for (int k = 0; k < 4; k++)
                            if (!((t > m_ap[k]) && (!m_open[k] || t >= m_pre[k]))) all_ok = 0;
                        e_grant = all_ok;
                    end
                    3'd6: begin
                        any_open = 0; all_ok = (t >= m_rfc);
                        for (int k = 0; k < 4; k++) begin
                            if (m_open[k]) any_open = 1;
                            if (!((t > m_ap[k]) && (t >= m_rp[k]))) all_ok = 0;
                        end
                        if (any_open) e_err = 1; else e_grant = all_ok;
                    end
                    default: ;
                endcase
            end
            chk(cur_req, "grant", 32'(grant), 32'(e_grant));
            chk(rst ? "R1" : (e_err ? "R9" : cur_req), "proto_err", 32'(proto_err), 32'(e_err));
            chk("R2", "strobes", 32'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}),
                32'(e_grant ? exp_pins(req_cmd) : 4'b1111));
            chk("R2", "cmd_ap", 32'(cmd_ap),
                32'(e_grant && ((req_cmd == 3'd5) || ((req_cmd == 3'd2 || req_cmd == 3'd3) && req_ap))));
            if (e_grant) chk("R2", "cmd_bank", 32'(cmd_bank), 32'(req_bank));
            chk(rst ? "R1" : cur_req, "bank_open", 32'(bank_open),
                32'({m_open[3], m_open[2], m_open[1], m_open[0]}));
            if (e_grant) begin
                case (req_cmd)
                    3'd1: begin
                        m_open[b] = 1; m_rd[b] = t + E_RCD; m_wr[b] = t + E_RCDW;
                        m_pre[b] = t + E_RAS; m_act[b] = t + E_RC; m_rrd = t + E_RRD;
                    end
                    3'd2, 3'd3: begin
                        m_pre[b] = mx(m_pre[b], t + ((req_cmd == 3'd2) ? E_RTP : E_WRA));
                        if (req_ap) begin
                            m_open[b] = 0; m_ap[b] = m_pre[b]; m_rp[b] = m_pre[b] + E_RP;
                            m_act[b] = mx(m_act[b], m_rp[b]);
                        end
                    end
                    3'd4, 3'd5: begin
                        for (int k = 0; k < 4; k++) begin
                            if (m_open[k] && (req_cmd == 3'd5 || k == b)) begin
                                m_open[k] = 0; m_rp[k] = t + E_RP; m_act[k] = mx(m_act[k], m_rp[k]);
                            end
                        end
                    end
                    3'd6: m_rfc = t + E_RFC;
                    default: ;
                endcase
            end
        end
        if (t > LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", t, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Drive at posedge+1; hold until granted or rejected; release after the edge.
    task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic ap);
        req_valid = 1'b1; req_cmd = c; req_bank = b; req_ap = ap;
        @(negedge clk); #3;
        while (!grant && !proto_err) begin
            @(negedge clk); #3;
        end
        @(posedge clk); #1;
        req_valid = 1'b0; req_ap = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cur_req = "R1"; idle(2);
        cur_req = "R6"; issue(3'd1, 2'd0, 0); issue(3'd1, 2'd1, 0); issue(3'd1, 2'd2, 0);
        cur_req = "R3"; issue(3'd3, 2'd1, 0); issue(3'd2, 2'd0, 0);
        cur_req = "R10"; issue(3'd3, 2'd0, 0); issue(3'd2, 2'd0, 0); issue(3'd2, 2'd2, 0);
        cur_req = "R4"; issue(3'd4, 2'd0, 0);
        cur_req = "R5"; issue(3'd1, 2'd0, 0);
        cur_req = "R9"; issue(3'd2, 2'd3, 0); issue(3'd1, 2'd0, 0); issue(3'd3, 2'd3, 0);
        cur_req = "R7"; issue(3'd3, 2'd1, 1); issue(3'd1, 2'd1, 0);
        issue(3'd2, 2'd2, 1); issue(3'd2, 2'd2, 0); issue(3'd1, 2'd2, 0);
        cur_req = "R8"; issue(3'd6, 2'd0, 0);
        cur_req = "R11"; issue(3'd5, 2'd0, 0);
        cur_req = "R8"; issue(3'd6, 2'd0, 0); issue(3'd1, 2'd3, 0); issue(3'd6, 2'd0, 0);
        cur_req = "R2"; req_valid = 1'b1; req_cmd = 3'd7; idle(0);
        repeat (3) begin @(posedge clk); #1; end
        req_cmd = 3'd0; repeat (2) begin @(posedge clk); #1; end
        cur_req = "R11"; issue(3'd3, 2'd3, 1); issue(3'd5, 2'd0, 0);
        cur_req = "R7"; issue(3'd1, 2'd3, 0);
        idle(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule